// File: doc/BRIEF.md
# Masked Sticky Event Status Register

This block keeps an 8-bit record of status events for an instrument's remote-control interface. The command parser, the command executor and the output queue each send single-cycle pulses on their own event inputs. Each pulse sets its bit in the register, and the bit then holds until something clears it. A host reads the register through a read strobe. The access returns the current contents and wipes the register on the next clock edge. A separate clear-status command input wipes it in the same way.

An 8-bit enable register sits alongside the event register and is written and read through a small register port. A bit that is set in both the event register and the enable register raises the summary output. That output drives bit 5 of the instrument's status byte. The top bit of the event register marks power-up: reset loads it as 1. Two positions in the register are permanently zero.

Top module: `evt_status_reg`

## Requirements
- R1: After reset the event register reads 0x80 (power-on flag set), the enable register reads 0x00 and the summary output is 0.
- R2: Event bits 6 and 1 always read 0.
- R3: The events set fixed bits: command error sets bit 5, execution error bit 4, device-dependent error bit 3, query error bit 2, operation complete bit 0. Each bit is 1 from the cycle after its pulse and stays 1 until a clear.
- R4: Event inputs pulsed in the same cycle all set their bits.
- R5: The summary output equals the OR over all bit positions of (event bit AND enable bit). It is combinational from the two registers, so an enable bit of 0 keeps its event from affecting the summary.
- R6: A write to the enable register loads the full 8-bit value, and that value reads back from the next cycle on.
- R7: While the read strobe is high, the read data shows the current event register. On the following cycle the register is 0, unless an event occurred in the read cycle.
- R8: A clear-status pulse leaves the event register at 0 on the following cycle, unless an event occurred in the same cycle.
- R9: An event in the same cycle as a read or a clear-status pulse still leaves its bit set afterwards, and the read data in that cycle shows the value from before the event.
- R10: Event-register reads and clear-status pulses leave the enable register unchanged.
- R11: Only reset sets the power-on bit (bit 7). Once a read or a clear has cleared it, no event input sets it again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ev_cmd_err_i | input | 1 | Command error pulse (sets bit 5) |
| ev_exe_err_i | input | 1 | Execution error pulse (sets bit 4) |
| ev_dev_err_i | input | 1 | Device-dependent error pulse (sets bit 3) |
| ev_qry_err_i | input | 1 | Query error pulse (sets bit 2) |
| ev_op_done_i | input | 1 | Operation complete pulse (sets bit 0) |
| evt_rd_i | input | 1 | Event register read strobe; clears the register after the cycle |
| clr_status_i | input | 1 | Clear-status command pulse |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 8 | Enable register write data |
| evt_rd_data_o | output | 8 | Current event register contents |
| en_rdata_o | output | 8 | Current enable register contents |
| summary_o | output | 1 | Masked summary, status byte bit 5 |

## Verification
The collision that matters here is an event pulse arriving in the same cycle as a clearing read or a clear-status pulse. The bench drives such a pulse together with the read strobe or the clear input in directed cases. In those cases it checks two things: the read data in that cycle must not yet show the new event, and on the next cycle the register must hold exactly the colliding event bits. The random phase then mixes events, reads, clears and enable writes freely, so these collisions recur many times. Every cycle is compared against a bench model in which set takes priority over clear.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;
  localparam int unsigned EVT_W = 8;

  // Bit positions; software decodes these, so they are fixed.
  localparam int unsigned POS_OP_DONE = 0;
  localparam int unsigned POS_QRY_ERR = 2;
  localparam int unsigned POS_DEV_ERR = 3;
  localparam int unsigned POS_EXE_ERR = 4;
  localparam int unsigned POS_CMD_ERR = 5;
  localparam int unsigned POS_PWR_ON  = 7;

  typedef logic [EVT_W-1:0] evt_vec_t;

  localparam evt_vec_t TIE_ZERO_MASK = evt_vec_t'(8'h42);
  localparam evt_vec_t EVT_RESET_VAL = evt_vec_t'(1) << POS_PWR_ON;
endpackage

// File: rtl/evt_rst_sync.sv
module evt_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/evt_sticky_bank.sv
module evt_sticky_bank
  import evt_status_pkg::*;
#(
  parameter evt_vec_t RESET_VAL = EVT_RESET_VAL,
  parameter evt_vec_t TIE_MASK  = TIE_ZERO_MASK
) (
  input  logic     clk,
  input  logic     rst_n,
  input  evt_vec_t set_i,
  input  logic     clr_i,
  output evt_vec_t q_o
);
  localparam evt_vec_t RST_EFF = RESET_VAL & ~TIE_MASK;

  evt_vec_t bits_q;
  evt_vec_t bits_d;
  logic     upd_en;

  // Set beats clear, so a colliding event survives the clear.
  always_comb begin
    for (int i = 0; i < int'(EVT_W); i++) begin
      bits_d[i] = TIE_MASK[i] ? 1'b0 : (set_i[i] | (bits_q[i] & ~clr_i));
    end
  end

  assign upd_en = clr_i | (|(set_i & ~TIE_MASK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      bits_q <= RST_EFF;
    else if (upd_en) bits_q <= bits_d;
  end

  assign q_o = bits_q;
endmodule

// File: rtl/evt_enable_reg.sv
module evt_enable_reg
  import evt_status_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     wr_i,
  input  evt_vec_t wdata_i,
  output evt_vec_t q_o
);
  evt_vec_t en_q;
  evt_vec_t en_d;

  always_comb begin
    en_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    en_q <= '0;
    else if (wr_i) en_q <= en_d;
  end

  assign q_o = en_q;
endmodule

// File: rtl/evt_status_reg.sv
module evt_status_reg
  import evt_status_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ev_cmd_err_i,
  input  logic       ev_exe_err_i,
  input  logic       ev_dev_err_i,
  input  logic       ev_qry_err_i,
  input  logic       ev_op_done_i,
  input  logic       evt_rd_i,
  input  logic       clr_status_i,
  input  logic       en_wr_i,
  input  logic [7:0] en_wdata_i,
  output logic [7:0] evt_rd_data_o,
  output logic [7:0] en_rdata_o,
  output logic       summary_o
);
  logic     rst_n_sync;
  evt_vec_t set_vec;
  evt_vec_t evt_q;
  evt_vec_t en_q;
  logic     clr_any;

  evt_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[POS_CMD_ERR] = ev_cmd_err_i;
    set_vec[POS_EXE_ERR] = ev_exe_err_i;
    set_vec[POS_DEV_ERR] = ev_dev_err_i;
    set_vec[POS_QRY_ERR] = ev_qry_err_i;
    set_vec[POS_OP_DONE] = ev_op_done_i;
  end

  assign clr_any = evt_rd_i | clr_status_i;

  evt_sticky_bank #(
    .RESET_VAL (EVT_RESET_VAL),
    .TIE_MASK  (TIE_ZERO_MASK)
  ) u_bank (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .set_i (set_vec),
    .clr_i (clr_any),
    .q_o   (evt_q)
  );

  evt_enable_reg u_enable (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_i    (en_wr_i),
    .wdata_i (en_wdata_i),
    .q_o     (en_q)
  );

  assign evt_rd_data_o = evt_q;
  assign en_rdata_o    = en_q;
  assign summary_o     = |(evt_q & en_q);
endmodule

// File: rtl/evt_status_chk.sv
module evt_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ev_cmd_err_i,
  input logic       ev_exe_err_i,
  input logic       ev_dev_err_i,
  input logic       ev_qry_err_i,
  input logic       ev_op_done_i,
  input logic       evt_rd_i,
  input logic       clr_status_i,
  input logic       en_wr_i,
  input logic [7:0] en_wdata_i,
  input logic [7:0] evt_rd_data_o,
  input logic [7:0] en_rdata_o,
  input logic       summary_o
);
  logic any_ev;
  assign any_ev = ev_cmd_err_i | ev_exe_err_i | ev_dev_err_i | ev_qry_err_i | ev_op_done_i;

  // R2
  tied_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd_data_o[6] == 1'b0) && (evt_rd_data_o[1] == 1'b0));

  // R3
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(evt_rd_i || clr_status_i) |=> ((evt_rd_data_o & $past(evt_rd_data_o)) == $past(evt_rd_data_o)));

  // R9
  cmd_err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_cmd_err_i |=> evt_rd_data_o[5]);

  // R9
  op_done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_op_done_i |=> evt_rd_data_o[0]);

  // R5
  summary_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    summary_o == |(evt_rd_data_o & en_rdata_o));

  // R7
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_rd_i && !any_ev) |=> (evt_rd_data_o == 8'h00));

  // R11
  pwr_on_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(evt_rd_data_o[7]) |-> !evt_rd_data_o[7]);

  // R6
  en_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_wr_i |=> (en_rdata_o == $past(en_wdata_i)));

  // R10
  en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr_i |=> $stable(en_rdata_o));
endmodule

bind evt_status_reg evt_status_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n_sync),
  .ev_cmd_err_i  (ev_cmd_err_i),
  .ev_exe_err_i  (ev_exe_err_i),
  .ev_dev_err_i  (ev_dev_err_i),
  .ev_qry_err_i  (ev_qry_err_i),
  .ev_op_done_i  (ev_op_done_i),
  .evt_rd_i      (evt_rd_i),
  .clr_status_i  (clr_status_i),
  .en_wr_i       (en_wr_i),
  .en_wdata_i    (en_wdata_i),
  .evt_rd_data_o (evt_rd_data_o),
  .en_rdata_o    (en_rdata_o),
  .summary_o     (summary_o)
);

// File: tb/evt_status_reg_tb.sv
module evt_status_reg_tb;
  logic       clk;
  logic       rst_n;
  logic       ev_cmd_err_i, ev_exe_err_i, ev_dev_err_i, ev_qry_err_i, ev_op_done_i;
  logic       evt_rd_i, clr_status_i, en_wr_i;
  logic [7:0] en_wdata_i;
  logic [7:0] evt_rd_data_o, en_rdata_o;
  logic       summary_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [7:0]  m_evt;
  logic [7:0]  m_en;
  bit          done = 0;

  evt_status_reg u_dut (
    .clk(clk), .rst_n(rst_n),
    .ev_cmd_err_i(ev_cmd_err_i), .ev_exe_err_i(ev_exe_err_i),
    .ev_dev_err_i(ev_dev_err_i), .ev_qry_err_i(ev_qry_err_i),
    .ev_op_done_i(ev_op_done_i), .evt_rd_i(evt_rd_i),
    .clr_status_i(clr_status_i), .en_wr_i(en_wr_i), .en_wdata_i(en_wdata_i),
    .evt_rd_data_o(evt_rd_data_o), .en_rdata_o(en_rdata_o), .summary_o(summary_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // Event set vector from the bit layout of R3 (bits 7, 6 and 1 never set).
  function automatic logic [7:0] ev_to_vec(logic [4:0] ev);
    return {2'b00, ev[4], ev[3], ev[2], ev[1], 1'b0, ev[0]};
  endfunction

  function automatic logic [7:0] next_evt(logic [7:0] cur, logic [7:0] setv, logic clr);
    return (clr ? 8'h00 : cur) | setv;
  endfunction

  task automatic chk8(string req, string what, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk8(req, "event register", evt_rd_data_o, m_evt);
    chk8("R2", "tied bits", evt_rd_data_o & 8'h42, 8'h00);
    chk8(req, "enable register", en_rdata_o, m_en);
    chk8("R5", "summary", {7'd0, summary_o}, {7'd0, |(m_evt & m_en)});
  endtask

  // ev order: {cmd, exe, dev, qry, opc}. Called and returns at a negedge.
  task automatic step(logic [4:0] ev, logic rd, logic clr, logic wr, logic [7:0] wd, string req);
    {ev_cmd_err_i, ev_exe_err_i, ev_dev_err_i, ev_qry_err_i, ev_op_done_i} = ev;
    evt_rd_i = rd; clr_status_i = clr; en_wr_i = wr; en_wdata_i = wd;
    #1;
    if (rd) chk8(req, "read data in read cycle", evt_rd_data_o, m_evt);
    @(posedge clk);
    m_evt = next_evt(m_evt, ev_to_vec(ev), rd | clr);
    if (wr) m_en = wd;
    @(negedge clk);
    {ev_cmd_err_i, ev_exe_err_i, ev_dev_err_i, ev_qry_err_i, ev_op_done_i} = '0;
    evt_rd_i = 0; clr_status_i = 0; en_wr_i = 0;
    check_all(req);
  endtask

  task automatic idle(string req);
    step(5'b0, 0, 0, 0, 8'h00, req);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] sv;
    void'($urandom(32'd20251));
    rst_n = 0;
    {ev_cmd_err_i, ev_exe_err_i, ev_dev_err_i, ev_qry_err_i, ev_op_done_i} = '0;
    evt_rd_i = 0; clr_status_i = 0; en_wr_i = 0; en_wdata_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    m_evt = 8'h80; m_en = 8'h00;
    // R1 reset state
    check_all("R1");

    // R6 enable write and readback; summary from power-on bit (R5)
    step(5'b0, 0, 0, 1, 8'h5A, "R6");
    step(5'b0, 0, 0, 1, 8'h80, "R6");
    chk8("R5", "summary with power-on enabled", {7'd0, summary_o}, 8'h01);

    // R10 read and clear do not touch enable; R7 read clears; R11 power-on gone
    step(5'b0, 1, 0, 0, 8'h00, "R7");
    chk8("R10", "enable after read", en_rdata_o, 8'h80);
    chk8("R11", "power-on after read", evt_rd_data_o, 8'h00);
    for (int i = 0; i < 3; i++) step(5'b11111, 0, 0, 0, 8'h00, "R11");
    chk8("R11", "power-on not set by events", evt_rd_data_o & 8'h80, 8'h00);
    step(5'b0, 0, 1, 0, 8'h00, "R8");
    chk8("R8", "after clear-status", evt_rd_data_o, 8'h00);
    chk8("R10", "enable after clear-status", en_rdata_o, 8'h80);

    // R3 each event sets its own bit and stays set
    for (int b = 0; b < 5; b++) begin
      step(5'b0, 1, 0, 1, 8'h00, "R3");
      step(5'(1 << b), 0, 0, 0, 8'h00, "R3");
      idle("R3"); idle("R3");
      chk8("R3", "single event bit", evt_rd_data_o, ev_to_vec(5'(1 << b)));
      chk8("R5", "masked summary", {7'd0, summary_o}, 8'h00);
    end

    // R4 all events in one cycle
    step(5'b0, 1, 0, 1, 8'h04, "R4");
    step(5'b11111, 0, 0, 0, 8'h00, "R4");
    chk8("R4", "all events together", evt_rd_data_o, 8'h3D);
    chk8("R5", "summary via query bit", {7'd0, summary_o}, 8'h01);

    // R9 event during read: old value read, new bit survives
    step(5'b00010, 1, 0, 0, 8'h00, "R9");
    chk8("R9", "event colliding with read", evt_rd_data_o, 8'h04);
    step(5'b10000, 0, 1, 0, 8'h00, "R9");
    chk8("R9", "event colliding with clear-status", evt_rd_data_o, 8'h20);
    chk8("R5", "summary dropped after clear", {7'd0, summary_o}, 8'h00);

    // Random mix
    for (int n = 0; n < 3000; n++) begin
      sv = 8'($urandom);
      step(5'($urandom) & 5'($urandom), ($urandom % 4) == 0, ($urandom % 8) == 0,
           ($urandom % 8) == 0, 8'($urandom), "R9");
    end
    done = 1;
    finish_run();
  end
endmodule